// File: doc/BRIEF.md
# Open-Row DRAM Bank Command Sequencer

This block turns block-sized read and write requests aimed at a single DRAM bank into a legal stream of bank commands. It leaves the bank's row buffer open after each access. It remembers which row is open and sorts every incoming request into one of three cases. A hit goes to the open row. An empty access finds no row open. A conflict goes to a row other than the open one. It then emits only the commands that case needs and moves the 64-byte block as eight column transfers on a 64-bit rank data bus.

Requests arrive on a valid/ready handshake. Only one request is in flight at a time, so `req_ready` is the only back-pressure. It drops in the cycle after a request is accepted and stays low until the eighth column transfer has been issued. While it is low, `req_valid` and the request fields are ignored. Write data is pulled one beat at a time: `wdata_ready` is high in exactly the cycles that carry a WR command, and `wdata` is taken in those cycles. Read data is pushed back with `rsp_valid` and cannot be stalled. The device side is modelled with its read data present in the same cycle as the RD command.

Minimum gaps between commands are parameters. The gap from PRECHARGE to ACTIVATE is `T_RP` cycles, and the gap from ACTIVATE to the first column command is `T_RCD` cycles. Down-counters enforce both gaps.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset: `req_ready` is 1, `cmd_op` is NOP, `rsp_valid` and `acc_valid` are 0, and no row is open, so the next access is classified empty.
- R2: One cycle after a request is accepted, `acc_valid` pulses for one cycle with `acc_kind` = 1 for a hit, 2 for empty, 3 for a conflict.
- R3: A hit issues no ACTIVATE and no PRECHARGE. Its first column command appears in the cycle after acceptance.
- R4: An empty access issues ACTIVATE (`cmd_op` = 1) with the request row on `cmd_row` in the cycle after acceptance. Its first column command comes exactly `T_RCD` cycles after the ACTIVATE.
- R5: A conflict issues PRECHARGE (`cmd_op` = 2) in the cycle after acceptance. ACTIVATE of the new row comes exactly `T_RP` cycles later, and the first column command comes `T_RCD` cycles after that.
- R6: A block is eight column commands on consecutive cycles: RD (`cmd_op` = 3) for a read, WR (`cmd_op` = 4) for a write. Beat b uses column {req_col[9:3], (req_col[2:0]+b) mod 8}. The block starts at the requested column and wraps inside its aligned group of eight.
- R7: `req_ready` is 0 from the cycle after acceptance through the cycle of the eighth column command, and 1 in the cycle after it. A `req_valid` held high while busy neither starts a request nor changes the open row.
- R8: One cycle after each RD command, `rsp_valid` is 1 and `rsp_data` holds the `dev_rdata` of that RD cycle. Chip lane k (bits 8k+7:8k) stays on lane k.
- R9: `wdata_ready` is 1 exactly in WR command cycles, and `dev_wdata` equals `wdata` in those cycles.
- R10: The row stays open after a block completes, so a later access to it is a hit. After a conflict, the new row is the open one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = block write, 0 = block read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Starting column |
| wdata | input | 8*LANES | Write beat, taken while wdata_ready is high |
| wdata_ready | output | 1 | Write beat consumed this cycle |
| cmd_op | output | 3 | 0 NOP, 1 ACTIVATE, 2 PRECHARGE, 3 RD, 4 WR |
| cmd_row | output | ROW_W | Row of the current request |
| cmd_col | output | COL_W | Column for RD/WR, zero otherwise |
| dev_wdata | output | 8*LANES | Data toward the rank for WR |
| dev_rdata | input | 8*LANES | Data from the rank in the RD cycle |
| rsp_valid | output | 1 | Read beat present |
| rsp_data | output | 8*LANES | Read beat |
| acc_valid | output | 1 | Classification pulse |
| acc_kind | output | 2 | 1 hit, 2 empty, 3 conflict |

## Verification
Counting from the cycle after acceptance as cycle 1, the first column command of a hit is due in cycle 1. For an empty access it is due in cycle 1+T_RCD, and for a conflict in 1+T_RP+T_RCD, with ACTIVATE in cycle 1 or 1+T_RP. Eight column cycles follow, and `req_ready` returns one cycle after the last of them. Read responses trail each RD by one register, and the classification pulse sits in cycle 1. The bench derives this schedule from the expected kind for every request and samples at every falling edge from cycle 1 to the ready cycle. Each output is compared to the value due in that exact cycle, so a command that comes early or late, or is missing, is caught.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    KIND_NONE     = 2'd0,
    KIND_HIT      = 2'd1,
    KIND_EMPTY    = 2'd2,
    KIND_CONFLICT = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_WAIT_RP,
    ST_ACT,
    ST_WAIT_RCD,
    ST_BURST
  } seq_st_e;
endpackage

// File: rtl/open_row_tracker.sv
module open_row_tracker
  import bank_seq_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_en,
  input  logic [ROW_W-1:0] act_row,
  input  logic             pre_en,
  input  logic [ROW_W-1:0] lookup_row,
  output kind_e            kind,
  output logic             open_valid
);
  logic [ROW_W-1:0] open_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_valid <= 1'b0;
      open_row   <= '0;
    end else if (pre_en) begin
      open_valid <= 1'b0;
    end else if (act_en) begin
      open_valid <= 1'b1;
      open_row   <= act_row;
    end
  end

  always_comb begin
    if (!open_valid)                kind = KIND_EMPTY;
    else if (lookup_row == open_row) kind = KIND_HIT;
    else                            kind = KIND_CONFLICT;
  end

  AST_ACT_ONLY_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |-> !open_valid); // R5
  AST_PRE_ONLY_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    pre_en |-> open_valid); // R5
  AST_ACT_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |=> open_valid); // R10
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          last
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt <= TW'(1));

  AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> cnt == '0); // R5
  AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !load) |=> cnt == $past(cnt) - 1'b1); // R4
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int BEATS = 8,
  localparam int BW = $clog2(BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [BW-1:0] idx,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (!rst_n) idx <= '0;
    else if (en) idx <= last ? '0 : idx + 1'b1;
  end

  assign last = (idx == BW'(BEATS - 1));

  AST_BEAT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && last) |=> idx == '0); // R6
  AST_BEAT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !last) |=> idx == $past(idx) + 1'b1); // R6
endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
  import bank_seq_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int BEATS = 8,
  parameter int LANES = 8,
  parameter int T_RCD = 3,
  parameter int T_RP  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ROW_W-1:0]   req_row,
  input  logic [COL_W-1:0]   req_col,
  input  logic [8*LANES-1:0] wdata,
  output logic               wdata_ready,
  output logic [2:0]         cmd_op,
  output logic [ROW_W-1:0]   cmd_row,
  output logic [COL_W-1:0]   cmd_col,
  output logic [8*LANES-1:0] dev_wdata,
  input  logic [8*LANES-1:0] dev_rdata,
  output logic               rsp_valid,
  output logic [8*LANES-1:0] rsp_data,
  output logic               acc_valid,
  output logic [1:0]         acc_kind
);
  localparam int BW     = $clog2(BEATS);
  localparam int GAPMAX = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int TW     = $clog2(GAPMAX + 1) + 1;

  seq_st_e          state, nxt;
  logic             lat_write;
  logic [ROW_W-1:0] lat_row;
  logic [COL_W-1:0] lat_col;
  kind_e            look_kind;
  logic             open_valid;
  logic             accept;
  logic             tmr_load, tmr_last;
  logic [TW-1:0]    tmr_val;
  logic [BW-1:0]    beat_idx;
  logic             beat_last;
  logic             in_burst;
  cmd_e             op;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_burst  = (state == ST_BURST);

  open_row_tracker #(.ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n),
    .act_en(state == ST_ACT), .act_row(lat_row),
    .pre_en(state == ST_PRE), .lookup_row(req_row),
    .kind(look_kind), .open_valid(open_valid)
  );

  assign tmr_load = (state == ST_PRE) || (state == ST_ACT);
  assign tmr_val  = (state == ST_PRE) ? TW'(T_RP - 1) : TW'(T_RCD - 1);

  gap_timer #(.TW(TW)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  beat_counter #(.BEATS(BEATS)) u_beat (
    .clk(clk), .rst_n(rst_n), .en(in_burst), .idx(beat_idx), .last(beat_last)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        unique case (look_kind)
          KIND_HIT:      nxt = ST_BURST;
          KIND_CONFLICT: nxt = ST_PRE;
          default:       nxt = ST_ACT;
        endcase
      end
      ST_PRE:      nxt = (T_RP > 1) ? ST_WAIT_RP : ST_ACT;
      ST_WAIT_RP:  if (tmr_last) nxt = ST_ACT;
      ST_ACT:      nxt = (T_RCD > 1) ? ST_WAIT_RCD : ST_BURST;
      ST_WAIT_RCD: if (tmr_last) nxt = ST_BURST;
      ST_BURST:    if (beat_last) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_write <= 1'b0;
      lat_row   <= '0;
      lat_col   <= '0;
      acc_valid <= 1'b0;
      acc_kind  <= KIND_NONE;
    end else begin
      state     <= nxt;
      acc_valid <= accept;
      if (accept) begin
        lat_write <= req_write;
        lat_row   <= req_row;
        lat_col   <= req_col;
        acc_kind  <= look_kind;
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_PRE:   op = CMD_PRE;
      ST_ACT:   op = CMD_ACT;
      ST_BURST: op = lat_write ? CMD_WR : CMD_RD;
      default:  op = CMD_NOP;
    endcase
  end

  assign cmd_op      = op;
  assign cmd_row     = lat_row;
  assign cmd_col     = in_burst ? {lat_col[COL_W-1:BW], BW'(lat_col[BW-1:0] + beat_idx)} : '0;
  assign wdata_ready = in_burst && lat_write;
  assign dev_wdata   = wdata;

  logic [7:0] lane_q [LANES];
  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= (op == CMD_RD);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)             lane_q[g] <= '0;
      else if (op == CMD_RD)  lane_q[g] <= dev_rdata[8*g +: 8];
    end
    assign rsp_data[8*g +: 8] = lane_q[g];
  end

  // gap checkers: cycles since the last ACTIVATE / PRECHARGE, saturating
  logic [TW-1:0] since_act, since_pre;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= TW'(T_RCD);
      since_pre <= TW'(T_RP);
    end else begin
      if (op == CMD_ACT)                  since_act <= TW'(1);
      else if (since_act < TW'(T_RCD))    since_act <= since_act + 1'b1;
      if (op == CMD_PRE)                  since_pre <= TW'(1);
      else if (since_pre < TW'(T_RP))     since_pre <= since_pre + 1'b1;
    end
  end

  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == CMD_RD || cmd_op == CMD_WR) |-> since_act >= TW'(T_RCD)); // R4
  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == CMD_ACT) |-> since_pre >= TW'(T_RP)); // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R7
  AST_CLASS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (acc_valid && acc_kind != KIND_NONE)); // R2
  AST_RD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == CMD_RD) |=> rsp_valid); // R8
  AST_COL_NEEDS_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == CMD_RD || cmd_op == CMD_WR) |-> open_valid); // R3
endmodule

// File: tb/tb_bank_cmd_seq.sv
`timescale 1ns/1ps
module tb_bank_cmd_seq;
  localparam int ROW_W = 14;
  localparam int COL_W = 10;
  localparam int BEATS = 8;
  localparam int LANES = 8;
  localparam int T_RCD = 3;
  localparam int T_RP  = 2;
  localparam int NV    = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic               req_write = 1'b0;
  logic [ROW_W-1:0]   req_row = '0;
  logic [COL_W-1:0]   req_col = '0;
  logic [8*LANES-1:0] wdata;
  logic               wdata_ready;
  logic [2:0]         cmd_op;
  logic [ROW_W-1:0]   cmd_row;
  logic [COL_W-1:0]   cmd_col;
  logic [8*LANES-1:0] dev_wdata;
  logic [8*LANES-1:0] dev_rdata;
  logic               rsp_valid;
  logic [8*LANES-1:0] rsp_data;
  logic               acc_valid;
  logic [1:0]         acc_kind;

  int applied = 0;
  int miscmp  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  bank_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .BEATS(BEATS), .LANES(LANES),
                 .T_RCD(T_RCD), .T_RP(T_RP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .wdata(wdata), .wdata_ready(wdata_ready), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .acc_valid(acc_valid), .acc_kind(acc_kind)
  );

  function automatic logic [63:0] rd_pat(input logic [COL_W-1:0] c);
    logic [63:0] p;
    for (int k = 0; k < 8; k++) p[8*k +: 8] = 8'(k << 5) ^ c[7:0];
    return p;
  endfunction

  function automatic logic [63:0] wr_pat(input logic [COL_W-1:0] c);
    return ~rd_pat(c) ^ {54'h0, c};
  endfunction

  always_comb dev_rdata = rd_pat(cmd_col);
  always_comb wdata     = wr_pat(cmd_col);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // {junk, write, row, col, kind}; kind 1 hit, 2 empty, 3 conflict
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 1'b0, 14'd5,      10'h010, 2'd2},
    {1'b0, 1'b0, 14'd5,      10'h023, 2'd1},
    {1'b1, 1'b1, 14'd5,      10'h047, 2'd1},
    {1'b0, 1'b1, 14'd9,      10'h008, 2'd3},
    {1'b1, 1'b0, 14'd9,      10'h3FD, 2'd1},
    {1'b0, 1'b0, 14'd2,      10'h3F8, 2'd3},
    {1'b0, 1'b1, 14'd2,      10'h001, 2'd1},
    {1'b0, 1'b0, 14'h3FFF,   10'h2A5, 2'd3}
  };

  // Called right after a falling edge with the DUT idle.
  task automatic run_req(input bit junk, input bit wr, input logic [ROW_W-1:0] row,
                         input logic [COL_W-1:0] col, input logic [1:0] kind);
    int first, last, act_at, pre_at;
    logic [COL_W-1:0] prev_col;
    chk("R7 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_write = wr; req_row = row; req_col = col;
    first  = (kind == 2'd1) ? 1 : (kind == 2'd2) ? 1 + T_RCD : 1 + T_RP + T_RCD;
    last   = first + BEATS;
    pre_at = (kind == 2'd3) ? 1 : -1;
    act_at = (kind == 2'd2) ? 1 : (kind == 2'd3) ? 1 + T_RP : -1;
    prev_col = '0;
    for (int c = 1; c <= last; c++) begin
      logic [2:0] eop;
      logic [COL_W-1:0] ecol;
      bit colcyc;
      @(negedge clk);
      colcyc = (c >= first) && (c < first + BEATS);
      ecol = colcyc ? {col[COL_W-1:3], 3'(col[2:0] + 3'(c - first))} : '0;
      if (c == pre_at)      eop = 3'd2;
      else if (c == act_at) eop = 3'd1;
      else if (colcyc)      eop = wr ? 3'd4 : 3'd3;
      else                  eop = 3'd0;
      if (kind == 2'd1) chk("R3 hit command", 64'(cmd_op), 64'(eop));
      else if (kind == 2'd2) chk("R4 empty command", 64'(cmd_op), 64'(eop));
      else chk("R5 conflict command", 64'(cmd_op), 64'(eop));
      if (colcyc) chk("R6 column", 64'(cmd_col), 64'(ecol));
      if (c == act_at) chk("R4 activate row", 64'(cmd_row), 64'(row));
      chk("R7 ready", 64'(req_ready), 64'(c == last));
      chk("R2 class pulse", 64'(acc_valid), 64'(c == 1));
      if (c == 1) chk("R2 class kind", 64'(acc_kind), 64'(kind));
      if (!wr) begin
        chk("R8 rsp valid", 64'(rsp_valid), 64'(c > first && c <= last));
        if (c > first && c <= last) chk("R8 rsp data lanes", rsp_data, rd_pat(prev_col));
      end else begin
        chk("R9 wdata ready", 64'(wdata_ready), 64'(colcyc));
        if (colcyc) chk("R9 write data", dev_wdata, wr_pat(ecol));
      end
      prev_col = ecol;
      if (c < last && junk) begin
        req_valid = 1'b1; req_row = ~row; req_write = ~wr;
      end else begin
        req_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ready", 64'(req_ready), 64'd1);
    chk("R1 reset cmd", 64'(cmd_op), 64'd0);
    chk("R1 reset rsp", 64'(rsp_valid), 64'd0);
    chk("R1 reset class", 64'(acc_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      run_req(v[27], v[26], v[25:12], v[11:2], v[1:0]);
    end
    // R1: reset closes the row left open by the last vector
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset cmd mid-run", 64'(cmd_op), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_req(1'b0, 1'b0, 14'h3FFF, 10'h000, 2'd2);
    // R10: row stays open after the block
    run_req(1'b0, 1'b1, 14'h3FFF, 10'h006, 2'd1);
    repeat (3) @(negedge clk);
    chk("R10 idle after block", 64'(cmd_op), 64'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog R7: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end
endmodule